// File: doc/BRIEF.md
# Inline Crypto Keyslot Register Bank

This block is the register-side home of the key configurations used by a storage host controller's inline encryption engine. Software programs each keyslot through a simple 32-bit register bus. A slot holds up to 512 bits of key material, a one-hot data-unit-size mask, a capability index, one spare configuration dword and an enable flag. A few read-only words at the bottom of the address space describe how many slots exist, where the slot array starts and which cipher capabilities the engine offers.

The transfer datapath looks up a slot by index and receives the key and its settings one clock later. A valid flag comes back with them, and it is high only for a slot that is enabled. A slot becomes usable only when its control dword is written with the enable bit set. Any later write to the key or spare dword of that slot withdraws it on the same clock edge, so the datapath never sees a partly rewritten key. Key material cannot be read back over the bus.

Top module: `keyslot_bank`

## Requirements
- R1: After a synchronous reset (`rst` high), every slot is disabled, its key, spare dword and control fields are zero, and all lookup outputs and `rdData` are zero.
- R2: Byte address 0x000 reads as {8'h00, BASE_PTR[7:0], NUM_SLOTS-1 [15:8], NUM_CAPS [7:0]}. With the defaults this is 0x00040302.
- R3: The word at byte address 4*(1+i), for i below NUM_CAPS, reads as capability entry i of CAP_TABLE, laid out as algorithm id [23:16], key-size code [15:8] (0 = invalid) and data-unit mask [7:0]. Word addresses past the last capability read as zero.
- R4: Slot s starts at byte address BASE_PTR*0x100 + s*0x80. Dword d of that slot sits at that start plus 4*d. Dwords 0 to 15 hold key material, dword 16 is control and dword 17 is the spare configuration dword.
- R5: Key dword k of a slot appears on `lkKey[32k+31:32k]`. For a two-key cipher, the second key half therefore starts at dword 8, which is bit 256.
- R6: A write to control dword 16 stores enable from bit 31, the capability index from [15:8] and the data-unit mask from [7:0], where mask bit n means 512*2^n bytes. The dword reads back with the other bits zero. A lookup issued in any later cycle returns these fields with `lkValid` high.
- R7: A write to a key dword or to dword 17 of an enabled slot stores the data and clears that slot's enable on the same clock edge.
- R8: Key dwords read as zero. Dwords 16 and 17 read back what is stored.
- R9: A lookup of a disabled slot or of an index at or above NUM_SLOTS returns `lkValid` low, with `lkKey`, `lkDuMask` and `lkCapIdx` all zero.
- R10: Writing zero to dword 16 disables the slot. Writes to the read-only words, to slot dwords 18 to 31 or outside the slot array change nothing, and those slot dwords read as zero.
- R11: `rdData` is registered. It shows the addressed word one cycle after `rdEn` and zero after any cycle without `rdEn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address of the access |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, one cycle after rdEn |
| lkIdx | input | 8 | Slot index looked up by the datapath |
| lkKey | output | 512 | Key of the looked-up slot |
| lkDuMask | output | 8 | Data-unit-size mask of the looked-up slot |
| lkCapIdx | output | 8 | Capability index of the looked-up slot |
| lkValid | output | 1 | Looked-up slot is enabled and in range |

## Verification
The lookup path is exercised with a slot that holds a single key dword, with a full sixteen-dword two-half key and with a freshly reset slot. These cases separate a wrong key-to-bit mapping from stale or uncleared storage. The withdrawal rule is tried separately through a key-dword write and through a spare-dword write, and re-enabling afterwards shows that the new data was kept while the enable had dropped. Register reads cover the descriptor words, a missing capability word, key dwords, unused slot dwords and writes aimed at read-only words. Out-of-range lookups are compared with lookups of in-range slots that were never enabled.

// File: rtl/keyslot_pkg.sv
package keyslot_pkg;
  localparam int IDX_W = 8;

  // strobes from the address decoder to the storage
  typedef struct packed {
    logic             keyWe;
    logic             ctlWe;
    logic             extWe;
    logic [IDX_W-1:0] slot;
    logic [3:0]       keyDw;
    logic             rdGlob;
    logic             rdCap;
    logic [IDX_W-1:0] capSel;
    logic             rdCtl;
    logic             rdExt;
  } strobe_t;

  typedef struct packed {
    logic       en;
    logic [7:0] capIdx;
    logic [7:0] duMask;
  } slotCtl_t;
endpackage

// File: rtl/keyslot_decode.sv
module keyslot_decode
  import keyslot_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NUM_SLOTS = 4,
  parameter int NUM_CAPS  = 2,
  parameter int BASE_PTR  = 4
) (
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output strobe_t           strb
);
  localparam int BASE_WORD   = BASE_PTR * 64;   // 0x100 bytes per pointer step
  localparam int SLOT_WORDS  = 32;              // 0x80 bytes per slot
  localparam int REGION_WORDS = NUM_SLOTS * SLOT_WORDS;

  logic [31:0] wordAddr;
  logic [31:0] offs;
  logic [4:0]  dwIdx;
  logic        inRegion;
  logic        capHit;

  always_comb begin
    wordAddr = 32'(addr >> 2);
    offs     = wordAddr - 32'(BASE_WORD);
    inRegion = (wordAddr >= 32'(BASE_WORD)) && (offs < 32'(REGION_WORDS));
    dwIdx    = offs[4:0];
    capHit   = (wordAddr >= 32'd1) && (wordAddr <= 32'(NUM_CAPS));

    strb        = '0;
    strb.slot   = IDX_W'(offs >> 5);
    strb.keyDw  = dwIdx[3:0];
    strb.keyWe  = wrEn && inRegion && (dwIdx < 5'd16);
    strb.ctlWe  = wrEn && inRegion && (dwIdx == 5'd16);
    strb.extWe  = wrEn && inRegion && (dwIdx == 5'd17);
    strb.rdCtl  = rdEn && inRegion && (dwIdx == 5'd16);
    strb.rdExt  = rdEn && inRegion && (dwIdx == 5'd17);
    strb.rdGlob = rdEn && (wordAddr == 32'd0);
    strb.rdCap  = rdEn && capHit;
    strb.capSel = IDX_W'(wordAddr - 32'd1);
  end
endmodule

// File: rtl/keyslot_store.sv
module keyslot_store
  import keyslot_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int NUM_CAPS  = 2,
  parameter int BASE_PTR  = 4,
  parameter logic [NUM_CAPS*32-1:0] CAP_TABLE = 64'h0001_0201_0004_0309
) (
  input  logic             clk,
  input  logic             rst,
  input  strobe_t          strb,
  input  logic [31:0]      wrData,
  input  logic [IDX_W-1:0] lkIdx,
  output logic [31:0]      rdData,
  output logic [511:0]     lkKey,
  output logic [7:0]       lkDuMask,
  output logic [7:0]       lkCapIdx,
  output logic             lkValid
);
  localparam int KEY_DW = 16;

  logic [31:0] keyMem [NUM_SLOTS][KEY_DW];
  logic [31:0] extReg [NUM_SLOTS];
  slotCtl_t    ctlReg [NUM_SLOTS];

  logic [31:0]  rdNext;
  logic [511:0] keyNext;
  slotCtl_t     ctlNext;
  logic         validNext;

  // storage: enable only rises on a control write, any other slot write drops it
  always_ff @(posedge clk) begin
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (rst) begin
        ctlReg[s] <= '0;
        extReg[s] <= '0;
        for (int k = 0; k < KEY_DW; k++) keyMem[s][k] <= '0;
      end else if (strb.slot == IDX_W'(s)) begin
        if (strb.ctlWe) begin
          ctlReg[s].en     <= wrData[31];
          ctlReg[s].capIdx <= wrData[15:8];
          ctlReg[s].duMask <= wrData[7:0];
        end else if (strb.keyWe || strb.extWe) begin
          ctlReg[s].en <= 1'b0;
        end
        if (strb.extWe) extReg[s] <= wrData;
        for (int k = 0; k < KEY_DW; k++)
          if (strb.keyWe && strb.keyDw == 4'(k)) keyMem[s][k] <= wrData;
      end
    end
  end

  // register read mux; key dwords never reach it
  always_comb begin
    rdNext = '0;
    if (strb.rdGlob)
      rdNext = {8'h00, 8'(BASE_PTR), 8'(NUM_SLOTS - 1), 8'(NUM_CAPS)};
    for (int c = 0; c < NUM_CAPS; c++)
      if (strb.rdCap && strb.capSel == IDX_W'(c)) rdNext = CAP_TABLE[c*32 +: 32];
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (strb.slot == IDX_W'(s)) begin
        if (strb.rdCtl) rdNext = {ctlReg[s].en, 15'b0, ctlReg[s].capIdx, ctlReg[s].duMask};
        if (strb.rdExt) rdNext = extReg[s];
      end
    end
  end

  // lookup select: only an enabled in-range slot drives the outputs
  always_comb begin
    keyNext   = '0;
    ctlNext   = '0;
    validNext = 1'b0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (lkIdx == IDX_W'(s) && ctlReg[s].en) begin
        validNext = 1'b1;
        ctlNext   = ctlReg[s];
        for (int k = 0; k < KEY_DW; k++) keyNext[32*k +: 32] = keyMem[s][k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdData   <= '0;
      lkKey    <= '0;
      lkDuMask <= '0;
      lkCapIdx <= '0;
      lkValid  <= 1'b0;
    end else begin
      rdData   <= rdNext;
      lkKey    <= keyNext;
      lkDuMask <= ctlNext.duMask;
      lkCapIdx <= ctlNext.capIdx;
      lkValid  <= validNext;
    end
  end
endmodule

// File: rtl/keyslot_bank.sv
module keyslot_bank
  import keyslot_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NUM_SLOTS = 4,
  parameter int NUM_CAPS  = 2,
  parameter int BASE_PTR  = 4,
  parameter logic [NUM_CAPS*32-1:0] CAP_TABLE = 64'h0001_0201_0004_0309
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  input  logic [7:0]        lkIdx,
  output logic [511:0]      lkKey,
  output logic [7:0]        lkDuMask,
  output logic [7:0]        lkCapIdx,
  output logic              lkValid
);
  strobe_t strb;

  keyslot_decode #(
    .ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS), .NUM_CAPS(NUM_CAPS), .BASE_PTR(BASE_PTR)
  ) decodeI (
    .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .strb(strb)
  );

  keyslot_store #(
    .NUM_SLOTS(NUM_SLOTS), .NUM_CAPS(NUM_CAPS), .BASE_PTR(BASE_PTR), .CAP_TABLE(CAP_TABLE)
  ) storeI (
    .clk(clk), .rst(rst), .strb(strb), .wrData(wrData), .lkIdx(lkIdx),
    .rdData(rdData), .lkKey(lkKey), .lkDuMask(lkDuMask), .lkCapIdx(lkCapIdx),
    .lkValid(lkValid)
  );
endmodule

// File: rtl/keyslot_bank_chk.sv
module keyslot_bank_chk #(
  parameter int ADDR_W    = 12,
  parameter int NUM_SLOTS = 4,
  parameter int BASE_PTR  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              wrEn,
  input logic              rdEn,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wrData,
  input logic [31:0]       rdData,
  input logic [7:0]        lkIdx,
  input logic [511:0]      lkKey,
  input logic [7:0]        lkDuMask,
  input logic [7:0]        lkCapIdx,
  input logic              lkValid
);
  localparam int LO_BYTE = BASE_PTR * 256;
  localparam int HI_BYTE = LO_BYTE + NUM_SLOTS * 128;

  logic [31:0] byteAddr;
  logic [31:0] relAddr;
  logic        slotHit;
  logic [7:0]  wrSlot;
  logic [4:0]  dword;
  logic        ctlWr;
  logic        dataWr;

  assign byteAddr = 32'(addr);
  assign relAddr  = byteAddr - 32'(LO_BYTE);
  assign slotHit  = (byteAddr >= 32'(LO_BYTE)) && (byteAddr < 32'(HI_BYTE));
  assign wrSlot   = 8'(relAddr / 32'd128);
  assign dword    = 5'((relAddr % 32'd128) / 32'd4);
  assign ctlWr    = wrEn && slotHit && dword == 5'd16;
  assign dataWr   = wrEn && slotHit && (dword <= 5'd15 || dword == 5'd17);

  // R6: an enabling control write shows up on a lookup of that slot
  assert_enable_visible_R6: assert property (@(posedge clk) disable iff (rst)
    (ctlWr && wrData[31] && lkIdx == wrSlot) ##1 (!wrEn && $stable(lkIdx))
      |=> (lkValid && lkDuMask == $past(wrData[7:0], 2) && lkCapIdx == $past(wrData[15:8], 2)));

  // R7: a key or spare dword write withdraws the slot
  assert_withdraw_R7: assert property (@(posedge clk) disable iff (rst)
    (dataWr && lkIdx == wrSlot) ##1 (!wrEn && $stable(lkIdx)) |=> !lkValid);

  // R9: out-of-range index never valid
  assert_range_R9: assert property (@(posedge clk) disable iff (rst)
    (lkIdx >= 8'(NUM_SLOTS)) |=> !lkValid);

  // R9: invalid lookup carries no key material
  assert_quiet_invalid_R9: assert property (@(posedge clk) disable iff (rst)
    !lkValid |-> (lkKey == '0 && lkDuMask == 8'd0 && lkCapIdx == 8'd0));

  // R11: no read strobe, no read data
  assert_rd_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !rdEn |=> rdData == 32'd0);
endmodule

bind keyslot_bank keyslot_bank_chk #(
  .ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS), .BASE_PTR(BASE_PTR)
) chkI (
  .clk(clk), .rst(rst), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData),
  .rdData(rdData), .lkIdx(lkIdx), .lkKey(lkKey), .lkDuMask(lkDuMask),
  .lkCapIdx(lkCapIdx), .lkValid(lkValid)
);

// File: tb/keyslot_bank_tb_top.sv
module keyslot_bank_tb_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wrEn = 1'b0;
  logic         rdEn = 1'b0;
  logic [11:0]  addr = '0;
  logic [31:0]  wrData = '0;
  logic [31:0]  rdData;
  logic [7:0]   lkIdx = '0;
  logic [511:0] lkKey;
  logic [7:0]   lkDuMask;
  logic [7:0]   lkCapIdx;
  logic         lkValid;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  keyslot_bank dut_i (
    .clk(clk), .rst(rst), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .lkIdx(lkIdx), .lkKey(lkKey), .lkDuMask(lkDuMask),
    .lkCapIdx(lkCapIdx), .lkValid(lkValid)
  );

  typedef struct packed {
    logic        isRd;
    logic [11:0] a;
    logic [31:0] val;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 12'h000, 32'h0004_0302, 4'd2},   // R2 descriptor word
    '{1'b1, 12'h004, 32'h0004_0309, 4'd3},   // R3 capability 0
    '{1'b1, 12'h008, 32'h0001_0201, 4'd3},   // R3 capability 1
    '{1'b1, 12'h00C, 32'h0000_0000, 4'd3},   // R3 past last capability
    '{1'b0, 12'h480, 32'h1111_1111, 4'd4},   // R4 slot 1 key dword 0
    '{1'b0, 12'h4C4, 32'hCAFE_0001, 4'd4},   // R4 slot 1 spare dword
    '{1'b0, 12'h4C0, 32'h8000_0102, 4'd6},   // R6 slot 1 enable
    '{1'b1, 12'h480, 32'h0000_0000, 4'd8},   // R8 key hidden
    '{1'b1, 12'h4C4, 32'hCAFE_0001, 4'd8},   // R8 spare readback
    '{1'b1, 12'h4C0, 32'h8000_0102, 4'd6}    // R6 control readback
  };

  function automatic logic [11:0] slotAt(input int s, input int d);
    return 12'(32'h400 + s * 32'h80 + d * 4);
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [511:0] act, input logic [511:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
    check(rdData == e, tag, $sformatf("read %03h", a), 512'(rdData), 512'(e));
  endtask

  task automatic look(input logic [7:0] idx, input logic v, input logic [511:0] k,
                      input logic [7:0] m, input logic [7:0] c, input string tag);
    @(negedge clk);
    lkIdx = idx;
    @(negedge clk);
    check(lkValid == v, tag, $sformatf("valid slot %0d", idx), 512'(lkValid), 512'(v));
    check(lkKey == k && lkDuMask == m && lkCapIdx == c, tag,
          $sformatf("key/mask/cap slot %0d (mask %0h cap %0h)", idx, lkDuMask, lkCapIdx),
          lkKey, k);
  endtask

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      finishRun();
    end
  end

  initial begin
    logic [511:0] xtsKey;
    logic [511:0] oneKey;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    for (int s = 0; s < 4; s++) look(8'(s), 1'b0, '0, 8'h0, 8'h0, "R1");
    rd(slotAt(0, 16), 32'h0, "R1");
    check(rdData == 32'h0, "R1", "rdData idle", 512'(rdData), 512'h0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].isRd) rd(VECS[i].a, VECS[i].val, $sformatf("R%0d", VECS[i].req));
      else wr(VECS[i].a, VECS[i].val);
    end

    // R11 read data returns to zero without rdEn
    @(negedge clk);
    check(rdData == 32'h0, "R11", "rdData after idle", 512'(rdData), 512'h0);

    // R6 / R5 slot 1 lookup
    oneKey = '0;
    oneKey[31:0] = 32'h1111_1111;
    look(8'd1, 1'b1, oneKey, 8'h02, 8'h01, "R6");

    // R5 full two-half key in slot 2
    xtsKey = '0;
    for (int k = 0; k < 16; k++) begin
      wr(slotAt(2, k), 32'hA500_0000 | 32'(k));
      xtsKey[32*k +: 32] = 32'hA500_0000 | 32'(k);
    end
    wr(slotAt(2, 17), 32'h0000_0077);
    wr(slotAt(2, 16), 32'h8000_0009);
    look(8'd2, 1'b1, xtsKey, 8'h09, 8'h00, "R5");
    check(lkKey[287:256] == 32'hA500_0008, "R5", "second half at bit 256",
          512'(lkKey[287:256]), 512'h A500_0008);

    // R7 key write withdraws, data kept
    wr(slotAt(1, 3), 32'h3333_3333);
    look(8'd1, 1'b0, '0, 8'h0, 8'h0, "R7");
    rd(slotAt(1, 16), 32'h0000_0102, "R7");
    wr(slotAt(1, 16), 32'h8000_0102);
    oneKey[127:96] = 32'h3333_3333;
    look(8'd1, 1'b1, oneKey, 8'h02, 8'h01, "R7");
    // R7 spare dword write withdraws
    wr(slotAt(1, 17), 32'h0BAD_F00D);
    look(8'd1, 1'b0, '0, 8'h0, 8'h0, "R7");
    rd(slotAt(1, 17), 32'h0BAD_F00D, "R8");

    // R9 out of range and never-enabled
    look(8'd5, 1'b0, '0, 8'h0, 8'h0, "R9");
    look(8'd255, 1'b0, '0, 8'h0, 8'h0, "R9");
    look(8'd0, 1'b0, '0, 8'h0, 8'h0, "R9");

    // R10 zero control disables; ignored writes
    wr(slotAt(2, 16), 32'h0);
    look(8'd2, 1'b0, '0, 8'h0, 8'h0, "R10");
    rd(slotAt(2, 16), 32'h0, "R10");
    wr(slotAt(2, 20), 32'hFFFF_FFFF);
    rd(slotAt(2, 20), 32'h0, "R10");
    wr(12'h000, 32'hFFFF_FFFF);
    rd(12'h000, 32'h0004_0302, "R10");
    wr(12'h004, 32'h0);
    rd(12'h004, 32'h0004_0309, "R10");
    wr(slotAt(2, 16), 32'h8000_0009);
    look(8'd2, 1'b1, xtsKey, 8'h09, 8'h00, "R10");

    // R1 reset in mid-run clears stored material
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    look(8'd2, 1'b0, '0, 8'h0, 8'h0, "R1");
    rd(slotAt(2, 17), 32'h0, "R1");
    wr(slotAt(2, 16), 32'h8000_0009);
    look(8'd2, 1'b1, '0, 8'h09, 8'h00, "R1");

    done = 1'b1;
    finishRun();
  end
endmodule